// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the address for each beat of a four-beat memory burst. A load strobe captures a full starting address from outside; from then on, every clock edge that sees the active-low advance strobe asserted moves the burst to its next beat, while an edge with the strobe released repeats the present beat as a wait cycle. Only the two lowest address bits move; everything above them is held at the captured value for the whole burst.

A static mode level picks the beat order. With the mode input low, the low bits count upward from the start value and roll over from 3 to 0. With it high, the low bits are the start value XORed with the beat number, the order processor caches use for critical-word-first line fills. The block reports both the full current address and the two-bit beat number, so a memory array and a data path can sit beside it.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets cur_addr and beat to zero.
- R2: When ld is high at a rising edge, the next cur_addr equals ext_addr and beat becomes 0, in either mode.
- R3: When ld and an active advance (adv_n low) arrive at the same edge, the load wins: the result is exactly that of R2.
- R4: With seq_mode low (linear order), cur_addr[1:0] equals (start low bits + beat) modulo 4; start 01 gives 01, 10, 11, 00.
- R5: With seq_mode high (interleaved order), cur_addr[1:0] equals start low bits XOR beat; start 10 gives 10, 11, 00, 01.
- R6: An edge with ld low and adv_n high leaves both cur_addr and beat unchanged (wait cycle).
- R7: cur_addr bits above bit 1 change only on a load, never by advancing, including across a wrap.
- R8: An advance while beat is 3 returns beat to 0 and cur_addr to the first address of the burst.
- R9: Each edge with ld low and adv_n low increases beat by exactly one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | Load strobe: capture ext_addr and restart the burst |
| ext_addr | input | AW | Starting address of a new burst |
| adv_n | input | 1 | Advance strobe, active low; high means wait |
| seq_mode | input | 1 | Beat order: 0 linear, 1 interleaved (static level) |
| cur_addr | output | AW | Address of the current beat |
| beat | output | 2 | Index of the current beat, 0 to 3 |

## Verification
The block keeps only a captured address and a two-bit beat counter, and both reach the ports combinationally, so any wrong internal value is visible on cur_addr or beat in the very cycle after the edge that produced it. A stuck or skipped counter step shows as a wrong beat and wrong low address bits one cycle later; a carry out of the low bits shows at once as a changed upper field. Random traffic in both orders, interleaved with wait cycles and restarting loads, is compared beat by beat against a model, and directed runs cover the wrap, the load-versus-advance collision and the reset state.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ext_addr,
  input  logic          adv_n,
  input  logic          seq_mode,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    beat
);

  localparam int UW = AW - 2;

  logic [AW-1:0] start_q;
  logic [1:0]    step_q;
  logic [1:0]    low;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      step_q  <= '0;
    end else if (ld) begin
      start_q <= ext_addr;
      step_q  <= '0;
    end else if (!adv_n) begin
      step_q  <= step_q + 2'd1;
    end
  end

  assign low      = seq_mode ? (start_q[1:0] ^ step_q) : (start_q[1:0] + step_q);
  assign cur_addr = {start_q[AW-1 -: UW], low};
  assign beat     = step_q;

endmodule

module burst_addr_seq_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          ld,
  input logic [AW-1:0] ext_addr,
  input logic          adv_n,
  input logic          seq_mode,
  input logic [AW-1:0] cur_addr,
  input logic [1:0]    beat
);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> (beat == 2'd0 && cur_addr == $past(ext_addr)));

  // R3: load with a simultaneous advance still restarts the burst
  p_load_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (ld && !adv_n) |=> (beat == 2'd0));

  p_linear_r4: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n && !seq_mode) |=>
      (!$stable(seq_mode) || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  p_interleave_r5: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n && seq_mode) |=>
      (!$stable(seq_mode) || (cur_addr[1:0] ^ beat) == $past(cur_addr[1:0] ^ beat)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ld && adv_n) |=>
      (!$stable(seq_mode) || ($stable(beat) && $stable(cur_addr))));

  p_upper_r7: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n && beat == 2'd3) |=> (beat == 2'd0));

  p_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n) |=> (beat == $past(beat) + 2'd1));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .ld(ld), .ext_addr(ext_addr), .adv_n(adv_n),
  .seq_mode(seq_mode), .cur_addr(cur_addr), .beat(beat)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          adv_n = 1'b1;
  logic          seq_mode = 1'b0;
  logic [AW-1:0] cur_addr;
  logic [1:0]    beat;

  int compared = 0;
  int mismatched = 0;
  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_beat = '0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .ld(ld), .ext_addr(ext_addr), .adv_n(adv_n),
    .seq_mode(seq_mode), .cur_addr(cur_addr), .beat(beat)
  );

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] b, logic m);
    return m ? (s ^ b) : (s + b);
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, logic [1:0] b, logic m);
    return {s[AW-1:2], exp_low(s[1:0], b, m)};
  endfunction

  task automatic check(string tag);
    logic [AW-1:0] ea;
    ea = exp_addr(m_start, m_beat, seq_mode);
    compared++;
    if (cur_addr !== ea || beat !== m_beat) begin
      mismatched++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, cur_addr, beat, ea, m_beat);
    end
  endtask

  task automatic cyc(logic r, logic l, logic [AW-1:0] a, logic av, logic m, string tag);
    rst = r; ld = l; ext_addr = a; adv_n = av; seq_mode = m;
    @(posedge clk);
    if (r) begin m_start = '0; m_beat = '0; end
    else if (l) begin m_start = a; m_beat = '0; end
    else if (!av) m_beat = m_beat + 2'd1;
    @(negedge clk);
    check(tag);
  endtask

  task automatic expect_low(logic [1:0] v, string tag);
    compared++;
    if (cur_addr[1:0] !== v) begin
      mismatched++;
      $display("FAIL %s: low=%b expected low=%b", tag, cur_addr[1:0], v);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic          m;
    void'($urandom(32'h5eed_0417));
    @(negedge clk);
    cyc(1, 0, '0, 1, 0, "R1 reset");
    cyc(1, 1, 17'h1ABCD, 0, 1, "R1 reset over load");

    // linear example start 01 -> 01,10,11,00 and wrap
    cyc(0, 1, 17'h0F0F1, 1, 0, "R2 load linear");
    expect_low(2'b01, "R4 beat0");
    cyc(0, 0, '0, 0, 0, "R4 adv1"); expect_low(2'b10, "R4 beat1");
    cyc(0, 0, '0, 0, 0, "R4 adv2"); expect_low(2'b11, "R4 beat2");
    cyc(0, 0, '0, 0, 0, "R4 adv3"); expect_low(2'b00, "R7 beat3 no carry");
    cyc(0, 0, '0, 0, 0, "R8 wrap linear"); expect_low(2'b01, "R8 back to start");

    // interleaved example start 10 -> 10,11,00,01
    cyc(0, 1, 17'h1FFFE, 1, 1, "R2 load interleaved");
    expect_low(2'b10, "R5 beat0");
    cyc(0, 0, '0, 1, 1, "R6 wait");
    cyc(0, 0, '0, 0, 1, "R5 adv1"); expect_low(2'b11, "R5 beat1");
    cyc(0, 0, '0, 1, 1, "R6 wait mid");
    cyc(0, 0, '0, 0, 1, "R5 adv2"); expect_low(2'b00, "R5 beat2");
    cyc(0, 0, '0, 0, 1, "R5 adv3"); expect_low(2'b01, "R5 beat3");
    cyc(0, 0, '0, 0, 1, "R8 wrap interleaved"); expect_low(2'b10, "R8 back to start");

    // load and advance together
    cyc(0, 0, '0, 0, 1, "R9 step");
    cyc(0, 1, 17'h00003, 0, 0, "R3 load beats advance");
    cyc(0, 0, '0, 0, 0, "R7 linear 3->0 no carry");
    expect_low(2'b00, "R7 low rolled");

    // constrained random traffic, mode held within each burst
    for (int burst = 0; burst < 600; burst++) begin
      a = AW'($urandom);
      m = $urandom_range(0, 1);
      cyc(0, 1, a, $urandom_range(0, 1), m, "R2 random load");
      for (int k = 0; k < $urandom_range(1, 9); k++) begin
        if ($urandom_range(0, 3) == 0)
          cyc(0, 0, AW'($urandom), 1, m, "R6 random wait");
        else
          cyc(0, 0, AW'($urandom), 0, m, m ? "R5 random" : "R4 random");
      end
      if ($urandom_range(0, 40) == 0) cyc(1, 0, a, 0, m, "R1 random reset");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule